// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder and Output Control

This block is the device-side control logic of an extended-data-out DRAM model. All strobes arrive active low and are sampled on a fast system clock. Edges are found by comparing each sample with the previous one. The block classifies every strobe sequence as one of eight cycle kinds and latches the multiplexed row and column addresses. It reads or writes a small internal array with a separate strobe for each byte lane, and decides when the data outputs are driven. A CBR refresh cycle is one in which either CAS strobe is low before RAS falls. Each such cycle advances an internal refresh row counter.

Read data is captured in an output latch when CAS falls. It stays valid after CAS rises while RAS is low, which is the extended-data-out behaviour. It also stays valid when RAS rises while CAS is still low, and the drivers turn off once both RAS and CAS are high. The data bus is split into an input, an output and an output-enable, so that a pad ring or bench can resolve the bidirectional pins.

Top module: `edo_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, dq_oe_o is 0, cycle_o is 0 (idle) and refresh_row_o is 0.
- R2: A RAS fall latches the row from addr_i[ROW_W-1:0]. A later CAS fall with we_ni high latches the column from addr_i[COL_W-1:0] and sets cycle_o to 1 (read). The word at index row*2^COL_W+column is then presented on dq_o, and dq_oe_o is 1 when oe_ni is low.
- R3: After CAS rises with RAS still low, dq_o and dq_oe_o hold their values. The first CAS fall after a RAS fall clears page_o, and each further CAS fall in the same RAS-low period sets page_o.
- R4: When we_ni is low at a CAS fall, dq_i is written at the addressed word, cycle_o becomes 2 (early write) and dq_oe_o stays 0 for the rest of the cycle.
- R5: cas_lo_ni gates writes to bits 7:0 and cas_hi_ni gates writes to bits 15:8. A lane whose strobe is high keeps its old contents.
- R6: When we_ni falls while CAS is low after a read-type CAS fall, dq_i is written at the latched address and dq_oe_o turns off. cycle_o becomes 4 (read-modify-write) if the drivers were on just before the fall, and 3 (late write) otherwise.
- R7: oe_ni high keeps dq_oe_o at 0 and leaves dq_o unchanged.
- R8: A RAS fall while both CAS strobes are high sets cycle_o to 5 (RAS-only refresh), and dq_oe_o stays 0.
- R9: A RAS fall while a CAS strobe is already low sets cycle_o to 6 (CBR) and adds one to refresh_row_o. dq_oe_o stays 0 and the array contents are unchanged.
- R10: refresh_row_o wraps from 2^REF_W-1 (1023 by default) to 0.
- R11: A CAS fall while RAS is high sets cycle_o to 7 (CAS-only) and leaves dq_oe_o at 0 and the array unchanged.
- R12: If RAS rises while CAS is low, dq_o and dq_oe_o keep their values. Once RAS and both CAS strobes are high, dq_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_lo_ni | input | 1 | Column strobe and write gate for the low byte, active low |
| cas_hi_ni | input | 1 | Column strobe and write gate for the high byte, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 2*BYTE_W | Write data |
| dq_o | output | 2*BYTE_W | Output latch contents |
| dq_oe_o | output | 1 | Output driver enable |
| cycle_o | output | 3 | Last classified cycle kind |
| page_o | output | 1 | Current access is a page-mode repeat |
| refresh_row_o | output | REF_W | Internal refresh row counter |

## Verification
Every result of the block is registered from the sampled strobes. A change applied to the inputs is therefore visible on every output just after the next rising edge, and array writes can be read back from the following access onward. The bench changes its inputs on falling edges and checks one falling edge later, so each check falls exactly one clock after its stimulus. The bench sweeps the whole 16-word array with early, byte-masked, late and read-modify-write accesses, and runs 1024 CBR cycles to cover the counter wrap.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_CAS_ONLY = 3'd7
  } cyc_e;
endpackage

// File: rtl/edo_edge_det.sv
module edo_edge_det #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] q;

  // strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '1;
    else         q <= sig_i;

  assign q_o    = q;
  assign fall_o = q & ~sig_i;
  assign rise_o = ~q & sig_i;
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int REF_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [REF_W-1:0] row_o
);
  logic [REF_W-1:0] cnt;

  // natural wrap at 2**REF_W
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt <= '0;
    else if (inc_i) cnt <= cnt + 1'b1;

  assign row_o = cnt;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int CELL_W = 4,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [CELL_W-1:0]       wr_addr_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [LANES*BYTE_W-1:0] wr_data_i,
  input  logic [CELL_W-1:0]       rd_addr_i,
  output logic [LANES*BYTE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << CELL_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i)
      if (wr_en_i && wr_be_i[b])
        lane_mem[wr_addr_i] <= wr_data_i[b*BYTE_W +: BYTE_W];

    assign rd_data_o[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr_i];
  end
endmodule

// File: rtl/edo_cycle_ctrl.sv
module edo_cycle_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int BYTE_W = 8,
  parameter int REF_W  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_ni,
  input  logic                  cas_lo_ni,
  input  logic                  cas_hi_ni,
  input  logic                  we_ni,
  input  logic                  oe_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*BYTE_W-1:0]   dq_i,
  output logic [2*BYTE_W-1:0]   dq_o,
  output logic                  dq_oe_o,
  output logic [2:0]            cycle_o,
  output logic                  page_o,
  output logic [REF_W-1:0]      refresh_row_o
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int CELL_W = ROW_W + COL_W;
  localparam int S_RAS = 0, S_CLO = 1, S_CHI = 2, S_WE = 3, S_OE = 4;

  logic [4:0] strb_q, strb_fall, strb_rise;

  edo_edge_det #(.N(5)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .sig_i ({oe_ni, we_ni, cas_hi_ni, cas_lo_ni, ras_ni}),
    .q_o (strb_q), .fall_o (strb_fall), .rise_o (strb_rise)
  );

  logic cas_idle_now, cas_idle_q, ras_fall, ras_rise, cas_fall, we_fall;
  assign cas_idle_now = cas_lo_ni & cas_hi_ni;
  assign cas_idle_q   = strb_q[S_CLO] & strb_q[S_CHI];
  assign ras_fall     = strb_fall[S_RAS];
  assign ras_rise     = strb_rise[S_RAS];
  assign cas_fall     = cas_idle_q & ~cas_idle_now;
  assign we_fall      = strb_fall[S_WE];

  logic ref_inc;
  assign ref_inc = ras_fall & ~cas_idle_q;

  edo_refresh_ctr #(.REF_W(REF_W)) u_ref (
    .clk_i (clk_i), .rst_ni (rst_ni), .inc_i (ref_inc), .row_o (refresh_row_o)
  );

  // state
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              open_q, open_d, seen_q, seen_d, page_q, page_d;
  logic              valid_q, valid_d, early_q, early_d, oe_q, oe_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  cyc_e              cyc_q, cyc_d;

  logic              wr_en;
  logic [CELL_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign rd_addr = {row_q, addr_i[COL_W-1:0]};

  edo_cell_array #(.CELL_W(CELL_W), .BYTE_W(BYTE_W), .LANES(2)) u_array (
    .clk_i (clk_i), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_be_i ({~cas_hi_ni, ~cas_lo_ni}), .wr_data_i (dq_i),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data)
  );

  always_comb begin
    row_d = row_q;  col_d = col_q;  open_d = open_q; seen_d = seen_q;
    page_d = page_q; valid_d = valid_q; early_d = early_q;
    dout_d = dout_q; cyc_d = cyc_q;
    wr_en = 1'b0;   wr_addr = {row_q, col_q};

    if (ras_fall) begin
      valid_d = 1'b0; early_d = 1'b0; page_d = 1'b0; seen_d = 1'b0;
      if (!cas_idle_q) begin
        cyc_d = CYC_CBR; open_d = 1'b0;
      end else begin
        cyc_d = CYC_RAS_ONLY; open_d = 1'b1; row_d = addr_i[ROW_W-1:0];
      end
    end else if (cas_fall) begin
      if (open_q) begin
        col_d  = addr_i[COL_W-1:0];
        page_d = seen_q;
        seen_d = 1'b1;
        if (!we_ni) begin
          wr_en = 1'b1; wr_addr = rd_addr;
          cyc_d = CYC_EARLY_WR; early_d = 1'b1; valid_d = 1'b0;
        end else begin
          dout_d = rd_data; valid_d = 1'b1; early_d = 1'b0; cyc_d = CYC_READ;
        end
      end else if (strb_q[S_RAS] && ras_ni) begin
        cyc_d = CYC_CAS_ONLY;
      end
    end else if (we_fall && open_q && !cas_idle_now && valid_q && !early_q) begin
      wr_en = 1'b1;
      cyc_d = oe_q ? CYC_RMW : CYC_LATE_WR;
    end

    if (ras_rise) open_d = 1'b0;
    if (ras_ni && cas_idle_now) valid_d = 1'b0;

    oe_d = valid_d & ~early_d & ~oe_ni & (we_ni | cas_idle_now);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      row_q <= '0; col_q <= '0; open_q <= 1'b0; seen_q <= 1'b0; page_q <= 1'b0;
      valid_q <= 1'b0; early_q <= 1'b0; oe_q <= 1'b0; dout_q <= '0; cyc_q <= CYC_IDLE;
    end else begin
      row_q <= row_d; col_q <= col_d; open_q <= open_d; seen_q <= seen_d;
      page_q <= page_d; valid_q <= valid_d; early_q <= early_d; oe_q <= oe_d;
      dout_q <= dout_d; cyc_q <= cyc_d;
    end

  assign dq_o    = dout_q;
  assign dq_oe_o = oe_q;
  assign cycle_o = cyc_q;
  assign page_o  = page_q;

  // R9
  cbr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_inc |=> refresh_row_o == $past(refresh_row_o) + 1'b1);
  // R9
  cbr_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_CBR) |-> !dq_oe_o);
  // R4
  early_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_EARLY_WR) |-> !dq_oe_o);
  // R8
  ras_only_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_RAS_ONLY) |-> !dq_oe_o);
  // R11
  cas_only_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == CYC_CAS_ONLY) |-> !dq_oe_o);
  // R3
  edo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !ras_ni && !cas_fall && !ras_fall) |=> $stable(dq_o));
endmodule

// File: tb/edo_cycle_ctrl_test.sv
module edo_cycle_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ras_ni = 1, cas_lo_ni = 1, cas_hi_ni = 1, we_ni = 1, oe_ni = 1;
  logic [9:0]  addr_i = '0;
  logic [15:0] dq_i = '0, dq_o;
  logic        dq_oe_o, page_o;
  logic [2:0]  cycle_o;
  logic [9:0]  refresh_row_o;

  int checks = 0, errors = 0;
  logic [15:0] model [16];
  int ref_exp = 0;

  always #4 clk = ~clk;

  edo_cycle_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_lo_ni(cas_lo_ni),
    .cas_hi_ni(cas_hi_ni), .we_ni(we_ni), .oe_ni(oe_ni), .addr_i(addr_i),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .cycle_o(cycle_o),
    .page_o(page_o), .refresh_row_o(refresh_row_o)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a + 1) * 16'h1357) ^ 16'h5A00;
  endfunction

  task automatic open_row(int r);
    addr_i = 10'(r); ras_ni = 0; step();
    chk("R8 cycle", cycle_o, 5); chk("R8 hiz", dq_oe_o, 0);
  endtask

  task automatic close_row();
    ras_ni = 1; step();
    chk("R12 off", dq_oe_o, 0); step();
  endtask

  task automatic col_read(int r, int c, logic oe_n, logic pg);
    logic [15:0] e = model[r*4+c];
    oe_ni = oe_n; we_ni = 1; addr_i = 10'(c); cas_lo_ni = 0; cas_hi_ni = 0; step();
    chk("R2 cycle", cycle_o, 1); chk("R2 data", dq_o, e);
    chk("R7 oe", dq_oe_o, !oe_n); chk("R3 page", page_o, pg);
    cas_lo_ni = 1; cas_hi_ni = 1; step();
    chk("R3 hold data", dq_o, e); chk("R3 hold oe", dq_oe_o, !oe_n);
  endtask

  task automatic col_write(int r, int c, logic [15:0] d, logic [1:0] be);
    we_ni = 0; dq_i = d; addr_i = 10'(c); cas_lo_ni = !be[0]; cas_hi_ni = !be[1]; oe_ni = 0;
    step();
    chk("R4 cycle", cycle_o, 2); chk("R4 hiz", dq_oe_o, 0);
    cas_lo_ni = 1; cas_hi_ni = 1; step();
    chk("R4 hiz after", dq_oe_o, 0);
    we_ni = 1; oe_ni = 1;
    if (be[0]) model[r*4+c][7:0]  = d[7:0];
    if (be[1]) model[r*4+c][15:8] = d[15:8];
  endtask

  task automatic read_all();
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 4; c++) col_read(r, c, 0, c != 0);
      close_row();
    end
  endtask

  task automatic late_write(int r, int c, logic [15:0] d, logic oe_n);
    open_row(r);
    oe_ni = oe_n; addr_i = 10'(c); cas_lo_ni = 0; cas_hi_ni = 0; step();
    chk("R6 read data", dq_o, model[r*4+c]);
    dq_i = d; we_ni = 0; step();
    chk("R6 cycle", cycle_o, oe_n ? 3 : 4); chk("R6 hiz", dq_oe_o, 0);
    we_ni = 1; cas_lo_ni = 1; cas_hi_ni = 1; oe_ni = 1; step();
    close_row();
    model[r*4+c] = d;
  endtask

  task automatic cbr();
    cas_lo_ni = 0; cas_hi_ni = 0; step();
    ras_ni = 0; step();
    ref_exp = (ref_exp + 1) % 1024;
    chk("R9 cycle", cycle_o, 6); chk("R9 hiz", dq_oe_o, 0);
    chk("R10 counter", refresh_row_o, ref_exp);
    ras_ni = 1; step(); cas_lo_ni = 1; cas_hi_ni = 1; step();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1 oe", dq_oe_o, 0); chk("R1 cycle", cycle_o, 0); chk("R1 refresh", refresh_row_o, 0);
    rst_ni = 1; step();

    // R4 sweep of early writes, full words
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 4; c++) col_write(r, c, pat(r*4+c), 2'b11);
      close_row();
    end
    read_all();

    // R5 byte lanes
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < 4; c++) col_write(r, c, ~pat(r*4+c+7), 2'((r*4+c) % 3 + 1));
      close_row();
    end
    read_all();

    // R6 late write and read-modify-write
    late_write(1, 2, 16'hBEEF, 1'b1);
    late_write(2, 3, 16'hC0DE, 1'b0);
    open_row(1); col_read(1, 2, 0, 0); close_row();
    open_row(2); col_read(2, 3, 0, 0); close_row();

    // R7 oe high
    open_row(0); col_read(0, 1, 1, 0); close_row();

    // R12 RAS rises while CAS low
    open_row(3);
    oe_ni = 0; addr_i = 10'd2; cas_lo_ni = 0; cas_hi_ni = 0; step();
    ras_ni = 1; step();
    chk("R12 hold oe", dq_oe_o, 1); chk("R12 hold data", dq_o, model[14]);
    cas_lo_ni = 1; cas_hi_ni = 1; step();
    chk("R12 off", dq_oe_o, 0); step();

    // R11 CAS-only
    dq_i = 16'hFFFF; we_ni = 0; addr_i = 10'd1;
    cas_lo_ni = 0; cas_hi_ni = 0; step();
    chk("R11 cycle", cycle_o, 7); chk("R11 hiz", dq_oe_o, 0);
    cas_lo_ni = 1; cas_hi_ni = 1; we_ni = 1; step();

    // R9 / R10 CBR sweep with wrap
    for (int i = 0; i < 1024; i++) cbr();
    chk("R10 wrapped", refresh_row_o, 0);

    // R9 R11 array unchanged
    read_all();

    finish_run();
  end
endmodule